// File: doc/BRIEF.md
# Memory-Mapped Configurable GPIO Port

This block is one 8-bit general-purpose I/O port that sits on a simple synchronous byte bus. Every pin has its own pair of control bits, one in a data register and one in a configuration register. Together they choose among four modes: floating input, input with weak pull-up, driven low and driven high. Software reaches the port through three consecutive byte addresses starting at a parameterised base. The data register sits at offset 0 and the configuration register at offset 1. Offset 2 is a read-only view of the pad levels, which pass through a two-flop synchroniser first.

A parameter mask marks pins that are input-only. The configuration bit of such a pin can never be set: writes of one are discarded and the bit reads back as zero. Its data bit is still stored and still selects the weak pull-up. The port can optionally raise a halt request. When a bus write to the data register carries a one in the designated halt bit (bit 7 by default), a small two-state machine emits a single-cycle pulse.

The halt machine has two states:
- `HALT_IDLE` waits for a trigger. On a data-register write with the halt bit set, it takes the transition `IDLE->PULSE`. Otherwise it stays in `IDLE`.
- `HALT_PULSE` drives `halt_req` high. It always takes the transition `PULSE->IDLE` on the next edge.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low and after reset, the data and configuration registers are zero. `pin_oe`, `pin_out`, `pin_pu` and `halt_req` are all zero, so every pin is a floating input.
- R2: Per pin, the pair {config, data} selects the mode. 00 gives oe=0 and pu=0. 01 gives oe=0 and pu=1. 10 gives oe=1 and out=0. 11 gives oe=1 and out=1. `pin_out` always equals the stored data bit, and `pin_pu` is never high on a pin whose `pin_oe` is high.
- R3: A write at BASE+0 (default 0xD0) loads the data register, and a write at BASE+1 loads the configuration register. The new value appears on the pin outputs in the cycle after the write edge.
- R4: Each pin's mode depends only on its own two bits. Any mix of modes across the eight pins is reproduced exactly.
- R5: For pins in the input-only mask (default bits 6 and 7), a configuration write of one is ignored. The configuration bit reads back as zero and `pin_oe` stays zero. The data bit is still stored and still enables the pull-up.
- R6: A read at BASE+2 returns the pad levels after two synchronising flops, whatever the configuration. Writes to BASE+2 change neither register.
- R7: A read at BASE+0 returns the stored data bits, not the pad levels. A read at BASE+1 returns the effective configuration bits.
- R8: A write to the data register with bit 7 set raises `halt_req` for exactly one cycle, in the cycle after the write edge. A write with bit 7 clear raises nothing. A trigger that arrives while the pulse is high is dropped, so the request is never held as a level.
- R9: `bus_rdata` is registered. It updates on the edge where `bus_rd` is high and holds otherwise. Reads outside BASE..BASE+2 return zero, and writes outside that window change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| halt_req | output | 1 | Single-cycle halt request pulse |

## Verification
A table of configuration/data pairs is written and checked. One entry pulls every pin up, one drives every pin, and the rest interleave patterns such as 0x0F/0x55, 0xAA/0x3C and 0x3F/0xC3. Together they separate the four modes per pin, show that the pins are independent, and show whether the input-only mask is applied on the configuration path or wrongly on the data path. Each data write is also checked for a halt pulse: the entries with bit 7 set and the entries with bit 7 clear tell the write trigger apart from a level on the stored bit. Directed cases then do four things. They drive pad values that differ from the stored data, which separates the pin-read view from the data view. They write to the read-only and unmapped addresses. They issue back-to-back halt writes to show that the pulse lasts exactly one cycle. They assert reset in the middle of a run.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    // Which register a bus address selects
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_PINS = 2'd2,
        SEL_NONE = 2'd3
    } port_sel_e;

    // Halt request sequencer states
    typedef enum logic {
        HALT_IDLE  = 1'b0,
        HALT_PULSE = 1'b1
    } halt_state_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE = 8'hD0
) (
    input  logic [ADDR_W-1:0] addr,
    output port_sel_e         sel
);

    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_CFG  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_PINS = ADDR_W'(2);

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = addr - BASE;
        if (offset == OFS_DATA)      sel = SEL_DATA;
        else if (offset == OFS_CFG)  sel = SEL_CFG;
        else if (offset == OFS_PINS) sel = SEL_PINS;
        else                         sel = SEL_NONE;
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
    parameter int             WIDTH     = 8,
    parameter logic [WIDTH-1:0] IN_ONLY = 8'hC0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data_en,
    input  logic             wr_cfg_en,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] cfg_q
);

    localparam logic [WIDTH-1:0] CFG_KEEP = ~IN_ONLY;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_data_en) begin
            data_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_cfg_en) begin
            cfg_q <= wdata & CFG_KEEP;
        end
    end

    // R3
    data_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_en |=> data_q == $past(wdata));

    // R5
    cfg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg_en |=> ((cfg_q & IN_ONLY) == '0) && ((cfg_q | IN_ONLY) == ($past(wdata) | IN_ONLY)));

    // R6
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg_en |=> $stable(cfg_q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_halt_fsm.sv
module gpio_halt_fsm
    import gpio_port_pkg::*;
#(
    parameter bit HALT_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    output logic halt_req
);

    generate
        if (HALT_EN) begin : g_halt
            halt_state_e state_q, state_d;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) state_q <= HALT_IDLE;
                else        state_q <= state_d;
            end

            always_comb begin
                state_d = state_q;
                unique case (state_q)
                    HALT_IDLE:  if (trigger) state_d = HALT_PULSE;
                    HALT_PULSE: state_d = HALT_IDLE;
                endcase
            end

            always_comb begin
                unique case (state_q)
                    HALT_IDLE:  halt_req = 1'b0;
                    HALT_PULSE: halt_req = 1'b1;
                endcase
            end

            // R8
            halt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                halt_req |=> !halt_req);

            // R8
            halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(halt_req) |-> $past(trigger));
        end else begin : g_no_halt
            assign halt_req = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int                WIDTH    = 8,
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] BASE     = 8'hD0,
    parameter logic [WIDTH-1:0]  IN_ONLY  = 8'hC0,
    parameter bit                HALT_EN  = 1'b1,
    parameter int                HALT_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pin_oe,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_pu,
    output logic              halt_req
);

    port_sel_e        sel;
    logic [WIDTH-1:0] data_q;
    logic [WIDTH-1:0] cfg_q;
    logic [WIDTH-1:0] pins_sync;
    logic             wr_data_en;
    logic             wr_cfg_en;
    logic             halt_trig;

    gpio_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr_data_en = bus_wr && (sel == SEL_DATA);
    assign wr_cfg_en  = bus_wr && (sel == SEL_CFG);
    assign halt_trig  = wr_data_en && bus_wdata[HALT_BIT];

    gpio_port_regs #(.WIDTH(WIDTH), .IN_ONLY(IN_ONLY)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (wr_data_en),
        .wr_cfg_en  (wr_cfg_en),
        .wdata      (bus_wdata),
        .data_q     (data_q),
        .cfg_q      (cfg_q)
    );

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pins_sync)
    );

    gpio_halt_fsm #(.HALT_EN(HALT_EN)) u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .trigger  (halt_trig),
        .halt_req (halt_req)
    );

    // Per-pin mode decode from {config, data}
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            assign pin_oe[i]  = cfg_q[i];
            assign pin_out[i] = data_q[i];
            assign pin_pu[i]  = ~cfg_q[i] & data_q[i];
        end
    endgenerate

    // Registered read path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (sel)
                SEL_DATA: bus_rdata <= data_q;
                SEL_CFG:  bus_rdata <= cfg_q;
                SEL_PINS: bus_rdata <= pins_sync;
                SEL_NONE: bus_rdata <= '0;
            endcase
        end
    end

    // R2
    pu_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R6
    pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_PINS) |=> bus_rdata == $past(pins_sync));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |=> bus_rdata == '0);

    // R5
    in_only_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & IN_ONLY) == '0);

endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pin_oe, pin_out, pin_pu;
    logic       halt_req;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
        .halt_req(halt_req)
    );

    localparam logic [7:0] A_DATA = 8'hD0;
    localparam logic [7:0] A_CFG  = 8'hD1;
    localparam logic [7:0] A_PINS = 8'hD2;
    localparam logic [7:0] A_OFF  = 8'hD3;

    // {cfg written, data written, expected oe, expected out, expected pu}
    localparam int NV = 6;
    localparam logic [39:0] VEC [NV] = '{
        {8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF},
        {8'hFF, 8'h00, 8'h3F, 8'h00, 8'h00},
        {8'h0F, 8'h55, 8'h0F, 8'h55, 8'h50},
        {8'hF0, 8'hA5, 8'h30, 8'hA5, 8'h85},
        {8'hAA, 8'h3C, 8'h2A, 8'h3C, 8'h14},
        {8'h3F, 8'hC3, 8'h3F, 8'hC3, 8'hC0}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 pu", pin_pu, 8'h00);
        chk("R1 halt", {7'd0, halt_req}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(A_CFG, rd);  chk("R1 cfg read", rd, 8'h00);
        bus_read(A_DATA, rd); chk("R1 data read", rd, 8'h00);

        // Vector table: R2 R3 R4 R5 R7 R8
        for (int v = 0; v < NV; v++) begin
            bus_write(A_CFG, VEC[v][39:32]);
            @(negedge clk);
            bus_addr = A_DATA; bus_wdata = VEC[v][31:24]; bus_wr = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0;
            chk("R8 halt after data write", {7'd0, halt_req}, {7'd0, VEC[v][31]});
            chk("R2 R4 oe", pin_oe, VEC[v][23:16]);
            chk("R2 out", pin_out, VEC[v][15:8]);
            chk("R2 R5 pu", pin_pu, VEC[v][7:0]);
            @(negedge clk);
            chk("R8 pulse ends", {7'd0, halt_req}, 8'h00);
            bus_read(A_CFG, rd);  chk("R5 R7 cfg readback", rd, VEC[v][23:16]);
            bus_read(A_DATA, rd); chk("R3 R7 data readback", rd, VEC[v][31:24]);
        end

        // R6: pin read follows synchronised pads, whatever the configuration
        bus_write(A_CFG, 8'hFF);
        bus_write(A_DATA, 8'h00);
        @(negedge clk); pad_in = 8'h5A;
        repeat (3) @(negedge clk);
        bus_read(A_PINS, rd); chk("R6 pins with outputs", rd, 8'h5A);
        // R7 data read is stored value, not pads
        bus_read(A_DATA, rd); chk("R7 data not pads", rd, 8'h00);
        bus_write(A_CFG, 8'h00);
        @(negedge clk); pad_in = 8'hA5;
        repeat (3) @(negedge clk);
        bus_read(A_PINS, rd); chk("R6 pins with inputs", rd, 8'hA5);

        // R6: write to pin-view address ignored
        bus_write(A_DATA, 8'h12);
        bus_write(A_CFG, 8'h21);
        bus_write(A_PINS, 8'hFF);
        bus_read(A_DATA, rd); chk("R6 pins write data kept", rd, 8'h12);
        bus_read(A_CFG, rd);  chk("R6 pins write cfg kept", rd, 8'h21);

        // R9: unmapped address
        bus_write(A_OFF, 8'hFF);
        bus_write(8'hCF, 8'hFF);
        chk("R9 unmapped write oe", pin_oe, 8'h21);
        chk("R9 unmapped write out", pin_out, 8'h12);
        bus_read(A_OFF, rd); chk("R9 unmapped read zero", rd, 8'h00);

        // R9: rdata holds when no read strobe
        bus_read(A_DATA, rd);
        bus_write(A_DATA, 8'h34);
        repeat (2) @(negedge clk);
        chk("R9 rdata held", bus_rdata, 8'h12);

        // R8: back-to-back halt writes give one pulse
        @(negedge clk);
        bus_addr = A_DATA; bus_wdata = 8'h80; bus_wr = 1'b1;
        @(negedge clk);
        chk("R8 first pulse", {7'd0, halt_req}, 8'h01);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R8 second trigger dropped", {7'd0, halt_req}, 8'h00);
        @(negedge clk);
        chk("R8 no level", {7'd0, halt_req}, 8'h00);
        // R8: rewriting with bit 7 still set pulses again
        bus_write(A_DATA, 8'h81);
        chk("R8 repeat pulse", {7'd0, halt_req}, 8'h01);

        // R1: reset in the middle of a run
        bus_write(A_CFG, 8'h3F);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 midrun oe", pin_oe, 8'h00);
        chk("R1 midrun out", pin_out, 8'h00);
        chk("R1 midrun pu", pin_pu, 8'h00);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule